// File: doc/BRIEF.md
# Debounced Press Counter With Single-Digit Display

This block counts presses of one mechanical push button and shows the running tally, modulo ten, on one seven-segment digit. The fast system clock is divided into a slow sampling strobe. The raw button is first brought into the clock domain through two flops. On every strobe it is then shifted into a short history. The button only counts as held once the whole history agrees. A press is counted once, on the rising edge of that filtered level, so contact bounce and a long hold each add exactly one.

The design uses a single clock. The strobe is a one-cycle enable and not a derived clock. A synchronous active-high reset clears the tally and the sample history. The digit enable output is a constant that selects the rightmost digit of a multi-digit display.

Top module: `press_tally`

## Requirements
- R1: A high `rst` at a clock edge sets the tally to 0, which has priority over a press in the same cycle. It also empties the sample history, so a button held through reset is counted once after the history fills again.
- R2: The sampling strobe is a one-cycle pulse. It occurs once every 2*HALF_DIV clock cycles.
- R3: `btn_i` is high when pressed. After a two-flop synchronizer it is sampled on each strobe. The filtered level is high only when the last SAMPLES samples (default 4) are all high, so a pulse that spans fewer than SAMPLES strobes is never counted.
- R4: Each rising edge of the filtered level adds exactly one to the tally. Holding the button, or bounce before it settles, adds nothing more.
- R5: The tally runs 0,1,...,9 and then wraps to 0 on the next press.
- R6: `seg_o[6:0]` is active-low, with bit 6 for segment a down to bit 0 for segment g. Digits 0..9 give 0000001, 1001111, 0010010, 0000110, 1001100, 0100100, 0100000, 0001111, 0000000, 0000100. Any other code gives the dash 1111110, which never appears in operation.
- R7: `an_o` is always 1110.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, clears tally and history |
| btn_i | input | 1 | Raw, asynchronous, bouncing button, high when pressed |
| seg_o | output | 7 | Active-low segment pattern, bit 6 = a ... bit 0 = g |
| an_o | output | 4 | Active-low digit enable, fixed 1110 |

## Verification
The assertions assume that `btn_i` may change in any cycle, with no minimum width and no relation to the strobe. They also assume that `rst` is the only other input. The stimulus keeps every intended press held for many strobes and every release open for many strobes. Random glitches are kept shorter than SAMPLES strobes and bounce bursts are kept short. As a result, the expected tally follows from counting intended presses alone.

// File: rtl/press_tally_pkg.sv
package press_tally_pkg;

    typedef logic [3:0] bcd_t;
    typedef logic [6:0] seg_t;

    localparam seg_t       SEG_DASH  = 7'b1111110;
    localparam logic [3:0] DIGIT_SEL = 4'b1110;
    localparam bcd_t       BCD_MAX   = 4'd9;

    typedef struct packed {
        logic [1:0] sync;
        logic       prev;
    } deb_flags_t;

    function automatic seg_t seg_of(input bcd_t d);
        seg_t s;
        case (d)
            4'd0:    s = 7'b0000001;
            4'd1:    s = 7'b1001111;
            4'd2:    s = 7'b0010010;
            4'd3:    s = 7'b0000110;
            4'd4:    s = 7'b1001100;
            4'd5:    s = 7'b0100100;
            4'd6:    s = 7'b0100000;
            4'd7:    s = 7'b0001111;
            4'd8:    s = 7'b0000000;
            4'd9:    s = 7'b0000100;
            default: s = SEG_DASH;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pt_tick_gen.sv
module pt_tick_gen #(
    parameter int unsigned PERIOD = 500000
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int unsigned W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [W-1:0] LAST = W'(PERIOD - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/pt_debounce.sv
module pt_debounce
    import press_tally_pkg::*;
#(
    parameter int unsigned SAMPLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic btn_i,
    output logic press_o
);
    deb_flags_t         fl_q;
    logic [SAMPLES-1:0] hist_q;
    logic               lvl;

    assign lvl = &hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fl_q   <= '0;
            hist_q <= '0;
        end else begin
            fl_q.sync <= {fl_q.sync[0], btn_i};
            if (tick_i) begin
                hist_q  <= {hist_q[SAMPLES-2:0], fl_q.sync[1]};
                fl_q.prev <= lvl;
            end
        end
    end

    assign press_o = tick_i & lvl & ~fl_q.prev;
endmodule

// File: rtl/pt_decade.sv
module pt_decade
    import press_tally_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic step_i,
    output bcd_t cnt_o
);
    bcd_t cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                   cnt_q <= '0;
        else if (step_i) begin
            if (cnt_q >= BCD_MAX)  cnt_q <= '0;
            else                   cnt_q <= cnt_q + 4'd1;
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/press_tally.sv
module press_tally
    import press_tally_pkg::*;
#(
    parameter int unsigned HALF_DIV = 250000,
    parameter int unsigned SAMPLES  = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       btn_i,
    output logic [6:0] seg_o,
    output logic [3:0] an_o
);
    localparam int unsigned PERIOD = 2 * HALF_DIV;

    logic tick;
    logic press;
    bcd_t cnt;

    pt_tick_gen #(.PERIOD(PERIOD)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    pt_debounce #(.SAMPLES(SAMPLES)) u_deb (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick),
        .btn_i   (btn_i),
        .press_o (press)
    );

    pt_decade u_cnt (
        .clk    (clk),
        .rst    (rst),
        .step_i (press),
        .cnt_o  (cnt)
    );

    assign seg_o = seg_of(cnt);
    assign an_o  = DIGIT_SEL;
endmodule

// File: rtl/pt_checker.sv
module pt_checker #(
    parameter int unsigned PERIOD = 8
) (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic       press,
    input logic [3:0] cnt,
    input logic [6:0] seg_o,
    input logic [3:0] an_o
);
    int unsigned gap_q;
    logic        seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= 0;
            seen_q <= 1'b0;
        end else if (tick) begin
            gap_q  <= 0;
            seen_q <= 1'b1;
        end else begin
            gap_q <= gap_q + 1;
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk) rst |=> cnt == 4'd0);
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        (tick && seen_q) |-> gap_q == PERIOD - 1);
    a_r2_tick_single: assert property (@(posedge clk) disable iff (rst)
        (PERIOD > 1 && tick) |=> !tick);
    a_r3_press_on_tick: assert property (@(posedge clk) disable iff (rst)
        press |-> tick);
    a_r4_hold_stable: assert property (@(posedge clk) disable iff (rst)
        !press |=> $stable(cnt));
    a_r4_step_one: assert property (@(posedge clk) disable iff (rst)
        (press && cnt < 4'd9) |=> cnt == $past(cnt) + 4'd1);
    a_r5_wrap: assert property (@(posedge clk) disable iff (rst)
        (press && cnt == 4'd9) |=> cnt == 4'd0);
    a_r6_no_dash: assert property (@(posedge clk) disable iff (rst)
        seg_o != 7'b1111110);
    a_r7_digit_sel: assert property (@(posedge clk) an_o == 4'b1110);
endmodule

bind press_tally pt_checker #(.PERIOD(2 * HALF_DIV)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .press (press),
    .cnt   (cnt),
    .seg_o (seg_o),
    .an_o  (an_o)
);

// File: tb/press_tally_tb.sv
module press_tally_tb;
    localparam int unsigned HALF = 2;
    localparam int unsigned PER  = 2 * HALF;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       btn = 1'b0;
    logic [6:0] seg;
    logic [3:0] an;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    int unsigned exp_cnt = 0;

    always #2 clk = ~clk;

    press_tally #(.HALF_DIV(HALF), .SAMPLES(4)) u_dut (
        .clk   (clk),
        .rst   (rst),
        .btn_i (btn),
        .seg_o (seg),
        .an_o  (an)
    );

    function automatic logic [6:0] ref_seg(input int unsigned d);
        case (d)
            0: return 7'b0000001;
            1: return 7'b1001111;
            2: return 7'b0010010;
            3: return 7'b0000110;
            4: return 7'b1001100;
            5: return 7'b0100100;
            6: return 7'b0100000;
            7: return 7'b0001111;
            8: return 7'b0000000;
            9: return 7'b0000100;
            default: return 7'b1111110;
        endcase
    endfunction

    task automatic cyc(input int unsigned n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_disp(input string req);
        n_chk++;
        if (seg !== ref_seg(exp_cnt % 10)) begin
            n_bad++;
            $display("FAIL %s seg actual=%b expected=%b", req, seg, ref_seg(exp_cnt % 10));
        end
        n_chk++;
        if (an !== 4'b1110) begin
            n_bad++;
            $display("FAIL R7 an actual=%b expected=1110", an);
        end
    endtask

    task automatic clean_press(input int unsigned hold);
        btn = 1'b1; cyc(hold);
        btn = 1'b0; cyc(12 * PER);
        exp_cnt++;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        cyc(3);
        rst = 1'b0;
        cyc(1);
        chk_disp("R1 reset shows 0");

        // R3: short glitch never counts
        btn = 1'b1; cyc(3); btn = 1'b0; cyc(12 * PER);
        chk_disp("R3 short glitch ignored");

        // R4: long hold counts once
        clean_press(40 * PER);
        chk_disp("R4 long hold counts once");

        // R4: bounce burst before settling counts once
        for (int i = 0; i < 6; i++) begin btn = ~btn; cyc(1); end
        clean_press(10 * PER);
        chk_disp("R4 bounce counts once");

        // R5: run through wrap
        for (int i = 0; i < 10; i++) clean_press(10 * PER);
        chk_disp("R5 wrap past 9");

        // R1: reset while held, history refills, one count after
        btn = 1'b1; cyc(10 * PER);
        rst = 1'b1; cyc(2); rst = 1'b0;
        exp_cnt = 0;
        chk_disp("R1 reset during hold");
        cyc(10 * PER);
        exp_cnt = 1;
        chk_disp("R1 held through reset counts once");
        btn = 1'b0; cyc(12 * PER);

        // R2/R3: random mix of clean presses and sub-window glitches
        for (int k = 0; k < 60; k++) begin
            int unsigned kind;
            kind = $urandom % 3;
            if (kind == 0) begin
                clean_press(8 * PER + ($urandom % (6 * PER)));
                chk_disp("R2 R4 random press");
            end else if (kind == 1) begin
                btn = 1'b1; cyc(1 + ($urandom % (2 * PER + 1)));
                btn = 1'b0; cyc(12 * PER);
                chk_disp("R3 random glitch");
            end else begin
                for (int i = 0; i < 1 + ($urandom % 5); i++) begin
                    btn = ~btn; cyc(1);
                end
                clean_press(9 * PER);
                chk_disp("R4 R6 random bounce");
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule